// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

This block is a synchronous down counter for frequency division. A parameter selects its modulus: decade, where the count wraps from 0 to 9, or binary, where it wraps from 0 to 2^WIDTH-1. The count steps down by one on each counting event. A counting event is a rising edge of the combined gate "tick high and hold low". That gate sees two kinds of edge: a tick rising while hold is low, and hold falling while tick is high. The second kind lets the hold input act as a falling-edge count source. The gate is sampled on the system clock `clk`, so the whole block runs on one clock.

A load input copies the parallel load value into the count at once, without waiting for `clk`, and takes precedence over counting. The clear input is asynchronous, zeroes the count and takes precedence over the load. The zero flag is high only when the count is zero, the chain input is high and clear is low.

For a single-stage divide-by-N, the zero flag drives the load input with N on the load value. The counter then reloads N each time it reaches zero. For a multi-digit divider:
- Each higher stage's zero flag drives the chain input of the stage below it.
- The lowest stage's zero flag drives the load input of every stage.
- Each higher stage takes its tick from the most significant count bit of the stage below. That bit rises only when the lower stage wraps.

Top module: `dcount_stage`

## Requirements
- R1: Each counting event lowers the count by one. The count is a plain binary number on `count_o`.
- R2: At a counting event with the count at zero and no load, the count becomes 9 in decade mode and 2^WIDTH-1 (15 for WIDTH=4) in binary mode.
- R3: A counting event is detected at the first rising edge of `clk` where `tick_i & ~hold_i` is 1 and was 0 at the previous edge. The count changes at that edge.
- R4: With `tick_i` high, a fall of `hold_i` is one counting event. A fall of `hold_i` while `tick_i` is low is not a counting event.
- R5: While `hold_i` is high, pulses on `tick_i` leave the count unchanged.
- R6: A rise of `load_i` puts `load_val_i` on `count_o` before any further `clk` edge. While `load_i` stays high, counting events do not change the count.
- R7: `zero_o` is 1 exactly when the count is zero, `chain_i` is 1 and `clr_i` is 0.
- R8: While `clr_i` is high, the count is zero and `zero_o` is 0, even with `load_i` and `chain_i` high.
- R9: In decade mode, a loaded value above 9 counts down one step at a time to 0 and then wraps to 9.
- R10: When `zero_o` is fed back to `load_i` with load value N (1 to 9), `zero_o` pulses once every N counting events.
- R11: A two-stage decade chain wired as described, loaded with digits H (upper) and L (lower, below 8), pulses the lower stage's `zero_o` once every 10*H+L counting events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the count gate is sampled on its rising edge |
| clr_i | input | 1 | Asynchronous clear, active high, highest priority |
| tick_i | input | 1 | Count source; a rise counts while hold is low |
| hold_i | input | 1 | Blocks counting when high; its fall counts while tick is high |
| load_i | input | 1 | Asynchronous parallel load enable, active high |
| load_val_i | input | WIDTH | Value copied into the count on load |
| chain_i | input | 1 | Qualifies the zero flag, for chaining stages |
| count_o | output | WIDTH | Current count |
| zero_o | output | 1 | High when count is zero, chain is high and clear is low |

## Verification
Two functions can act in the same cycle. In the first case, the counting event that brings the count to zero also raises `zero_o`, and the fed-back load then lands a moment later, before the next `clk` edge. The bench provokes this with a short delay on the feedback path. It sweeps every N from 1 to 9 and several two-digit chains, and judges the result by counting zero pulses against the arithmetic quotient of events over N after every event. In the second case, counting events arrive while a load is held high, or while hold is high. There the bench expects the count to stay frozen at the loaded value or at its previous value.

// File: rtl/dcount_pkg.sv
package dcount_pkg;
   typedef enum logic {
      RADIX_HEX = 1'b0,
      RADIX_DEC = 1'b1
   } radix_e;

   localparam int unsigned DEC_TOP = 9;
endpackage

// File: rtl/dcount_evt.sv
module dcount_evt (
   input  logic clk,
   input  logic clr_i,
   input  logic tick_i,
   input  logic hold_i,
   output logic ev_o
);
   logic gate_w;
   logic gate_q;

   // Combined gate: tick rising with hold low, or hold falling with tick high
   assign gate_w = tick_i & ~hold_i;

   always_ff @(posedge clk or posedge clr_i) begin
      if (clr_i) gate_q <= 1'b0;
      else       gate_q <= gate_w;
   end

   assign ev_o = gate_w & ~gate_q;
endmodule

// File: rtl/dcount_step.sv
module dcount_step
   import dcount_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter radix_e      RADIX = RADIX_DEC
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o
);
   generate
      if (RADIX == RADIX_DEC) begin : g_dec
         localparam logic [WIDTH-1:0] WRAP = WIDTH'(DEC_TOP);
         always_comb begin
            if (cur_i == '0) nxt_o = WRAP;
            else             nxt_o = cur_i - WIDTH'(1);
         end
      end else begin : g_hex
         assign nxt_o = cur_i - WIDTH'(1);
      end
   endgenerate
endmodule

// File: rtl/dcount_zero.sv
module dcount_zero #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] cnt_i,
   input  logic             chain_i,
   input  logic             clr_i,
   output logic             zero_o
);
   assign zero_o = (cnt_i == '0) & chain_i & ~clr_i;
endmodule

// File: rtl/dcount_stage.sv
module dcount_stage
   import dcount_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter radix_e      RADIX = RADIX_DEC
) (
   input  logic             clk,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             hold_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             chain_i,
   output logic [WIDTH-1:0] count_o,
   output logic             zero_o
);
   localparam logic [WIDTH-1:0] TOP_VAL =
      (RADIX == RADIX_DEC) ? WIDTH'(DEC_TOP) : {WIDTH{1'b1}};

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("dcount_stage: WIDTH must be at least 1");
      end
      if (RADIX == RADIX_DEC && WIDTH < 4) begin : g_bad_dec
         $error("dcount_stage: decade mode needs WIDTH of 4 or more");
      end
   endgenerate

   logic             ev_w;
   logic [WIDTH-1:0] nxt_w;
   logic [WIDTH-1:0] cnt_q;

   dcount_evt u_evt (
      .clk    (clk),
      .clr_i  (clr_i),
      .tick_i (tick_i),
      .hold_i (hold_i),
      .ev_o   (ev_w)
   );

   dcount_step #(.WIDTH(WIDTH), .RADIX(RADIX)) u_step (
      .cur_i (cnt_q),
      .nxt_o (nxt_w)
   );

   // Clear beats load, load beats counting; both act without clk
   always_ff @(posedge clk or posedge clr_i or posedge load_i) begin
      if (clr_i)       cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (ev_w)   cnt_q <= nxt_w;
   end

   dcount_zero #(.WIDTH(WIDTH)) u_zero (
      .cnt_i   (cnt_q),
      .chain_i (chain_i),
      .clr_i   (clr_i),
      .zero_o  (zero_o)
   );

   assign count_o = cnt_q;

   assert_wrap_R2: assert property (@(posedge clk) disable iff (clr_i)
      (ev_w && !load_i && cnt_q == '0) |=> (cnt_q == TOP_VAL || load_i))
      else $error("R2: wrap from zero did not reach top value");

   assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (clr_i)
      (hold_i && $past(hold_i)) |-> !ev_w)
      else $error("R5: counting event seen while hold high");

   assert_load_wins_R6: assert property (@(posedge clk) disable iff (clr_i)
      (load_i && $past(load_i) && !$past(clr_i)) |-> (cnt_q == $past(load_val_i)))
      else $error("R6: held load did not keep load value");

   assert_zero_flag_R7: assert property (@(posedge clk)
      zero_o |-> (count_o == '0 && chain_i && !clr_i))
      else $error("R7: zero flag high without its conditions");

   assert_clear_R8: assert property (@(posedge clk)
      (clr_i && $past(clr_i)) |-> (count_o == '0 && !zero_o))
      else $error("R8: clear did not hold count and flag low");
endmodule

// File: tb/dcount_stage_bench.sv
`timescale 1ns/1ps
module dcount_stage_bench;
   import dcount_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       clr_r = 1'b1;
   logic       tick_r = 1'b0;
   logic       hold_r = 1'b0;
   logic       load_man = 1'b0;
   logic       fb_mode = 1'b0;
   logic [3:0] data_r = 4'd0;
   logic       chain_r = 1'b0;
   logic [3:0] top_cnt, hex_cnt;
   logic       top_zero, hex_zero, top_zd, top_load;

   logic       cas_tick = 1'b0;
   logic [3:0] cas_h = 4'd0, cas_l = 4'd0;
   logic [3:0] lo_cnt, hi_cnt;
   logic       lo_zero, hi_zero, cas_zd;

   int n_chk = 0;
   int n_fail = 0;
   int zc = 0;
   int cz = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign #1 top_zd = top_zero;
   assign #1 cas_zd = lo_zero;
   assign top_load = fb_mode ? top_zd : load_man;

   dcount_stage #(.WIDTH(4), .RADIX(RADIX_DEC)) u_dcount_stage (
      .clk(clk), .clr_i(clr_r), .tick_i(tick_r), .hold_i(hold_r),
      .load_i(top_load), .load_val_i(data_r), .chain_i(chain_r),
      .count_o(top_cnt), .zero_o(top_zero));

   dcount_stage #(.WIDTH(4), .RADIX(RADIX_HEX)) u_dcount_stage_hex (
      .clk(clk), .clr_i(clr_r), .tick_i(tick_r), .hold_i(hold_r),
      .load_i(load_man), .load_val_i(data_r), .chain_i(chain_r),
      .count_o(hex_cnt), .zero_o(hex_zero));

   dcount_stage #(.WIDTH(4), .RADIX(RADIX_DEC)) u_dcount_stage_lo (
      .clk(clk), .clr_i(clr_r), .tick_i(cas_tick), .hold_i(1'b0),
      .load_i(cas_zd), .load_val_i(cas_l), .chain_i(hi_zero),
      .count_o(lo_cnt), .zero_o(lo_zero));

   dcount_stage #(.WIDTH(4), .RADIX(RADIX_DEC)) u_dcount_stage_hi (
      .clk(clk), .clr_i(clr_r), .tick_i(lo_cnt[3]), .hold_i(1'b0),
      .load_i(cas_zd), .load_val_i(cas_h), .chain_i(1'b1),
      .count_o(hi_cnt), .zero_o(hi_zero));

   always @(posedge top_zero) if (fb_mode) zc = zc + 1;
   always @(posedge lo_zero) cz = cz + 1;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_tick();
      tick_r = 1'b1;
      nclk(1);
      tick_r = 1'b0;
      nclk(1);
   endtask

   task automatic pulse_cas();
      cas_tick = 1'b1;
      nclk(1);
      cas_tick = 1'b0;
      nclk(1);
   endtask

   function automatic int dec_dn(input int v);
      return (v == 0) ? 9 : v - 1;
   endfunction

   function automatic int hex_dn(input int v);
      return (v + 15) % 16;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int e_dec, e_hex, hs[4], ls[4];
      // R8: clear holds zero even with load and chain high
      clr_r = 1'b1; load_man = 1'b1; data_r = 4'd5; chain_r = 1'b1;
      nclk(3);
      check("R8 count in clear", top_cnt, 0);
      check("R8 zero in clear", top_zero, 0);
      load_man = 1'b0;
      nclk(1);
      clr_r = 1'b0;
      nclk(1);
      check("R7 zero with chain high", top_zero, 1);
      chain_r = 1'b0;
      #1 check("R7 zero with chain low", top_zero, 0);
      chain_r = 1'b1;
      nclk(1);
      clr_r = 1'b1;
      #1 check("R8 zero forced low by clear", top_zero, 0);
      nclk(1);
      clr_r = 1'b0;
      nclk(2);

      // R6: load acts between clock edges and beats counting
      @(posedge clk);
      #3 data_r = 4'd7; load_man = 1'b1;
      #1 check("R6 immediate load", top_cnt, 7);
      nclk(1);
      pulse_tick();
      pulse_tick();
      check("R6 load overrides count", top_cnt, 7);
      load_man = 1'b0;
      nclk(2);

      // R3: change lands at the edge after the tick rise
      tick_r = 1'b1;
      #2 check("R3 no change before edge", top_cnt, 7);
      @(posedge clk);
      #1 check("R3 change at edge", top_cnt, 6);
      nclk(1);
      tick_r = 1'b0;
      nclk(1);

      // R1 R2 R7: sweep down through wrap in both radices
      e_dec = 6; e_hex = 6;
      for (int k = 0; k < 20; k++) begin
         pulse_tick();
         e_dec = dec_dn(e_dec);
         e_hex = hex_dn(e_hex);
         check((e_dec == 9) ? "R2 decade wrap" : "R1 decade step", top_cnt, e_dec);
         check((e_hex == 15) ? "R2 binary wrap" : "R1 binary step", hex_cnt, e_hex);
         check("R7 zero tracks count", top_zero, (e_dec == 0) ? 1 : 0);
      end

      // R5: hold blocks tick pulses
      hold_r = 1'b1;
      nclk(1);
      pulse_tick();
      pulse_tick();
      check("R5 hold blocks count", top_cnt, e_dec);
      // R4: hold falling with tick high is one event
      tick_r = 1'b1;
      nclk(2);
      hold_r = 1'b0;
      nclk(2);
      e_dec = dec_dn(e_dec);
      check("R4 hold fall counts", top_cnt, e_dec);
      tick_r = 1'b0;
      hold_r = 1'b1;
      nclk(2);
      hold_r = 1'b0;
      nclk(2);
      check("R4 hold fall with tick low ignored", top_cnt, e_dec);

      // R9: decade load above nine
      data_r = 4'd13; load_man = 1'b1;
      nclk(1);
      load_man = 1'b0;
      nclk(1);
      e_dec = 13;
      for (int k = 0; k < 16; k++) begin
         pulse_tick();
         e_dec = dec_dn(e_dec);
         check("R9 decade from above nine", top_cnt, e_dec);
      end

      // R10: single-stage divide by N
      for (int n = 1; n <= 9; n++) begin
         clr_r = 1'b1; fb_mode = 1'b1; chain_r = 1'b1; data_r = 4'(n);
         nclk(2);
         clr_r = 1'b0;
         nclk(2);
         zc = 0;
         check("R10 reload value", top_cnt, n);
         for (int k = 1; k <= 3 * n; k++) begin
            pulse_tick();
            check("R10 divide ratio", zc, k / n);
         end
      end
      fb_mode = 1'b0;

      // R11: two-stage decade chain
      hs = '{1, 2, 0, 3};
      ls = '{3, 5, 7, 0};
      for (int p = 0; p < 4; p++) begin
         int nn;
         nn = 10 * hs[p] + ls[p];
         clr_r = 1'b1; cas_h = 4'(hs[p]); cas_l = 4'(ls[p]);
         nclk(2);
         clr_r = 1'b0;
         nclk(3);
         cz = 0;
         check("R11 chain loaded", 10 * hi_cnt + lo_cnt, nn);
         for (int k = 1; k <= 3 * nn; k++) begin
            pulse_cas();
            check("R11 chain divide ratio", cz, k / nn);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule